// File: doc/BRIEF.md
# Seconds Counter with Match Alarm and Periodic Interrupt

This peripheral keeps time as a free-running 32-bit seconds count on a simple register bus. A tick strobe at 32768 Hz feeds a prescaler. While counting is enabled, the prescaler advances the count by one after each full set of ticks. Software reads the count, preloads it and programs a match value. When the count becomes equal to the match value, a sticky alarm status bit is raised.

A second source, a down-counting periodic timer, runs directly at the tick rate. It raises its own status bit each time it expires and then reloads itself. Each source has a raw bit, a mask bit, a masked view and a write-one-to-clear bit. All masked bits are combined into one interrupt line.

Bus writes take effect at the clock edge where `bus_sel` and `bus_we` are high. Reads are combinational from `bus_addr`. The word is selected by `bus_addr[5:2]`.

Top module: `rtc_match_alarm`

## Requirements
- R1: After reset, the count, match, load, control, mask, raw status and all periodic-timer registers read zero, and `irq` is low.
- R2: A write to offset 0x08 places the written value in the count at the next clock edge. It also restarts the prescaler phase, so the next increment needs a full `PRESCALE` ticks. Reading 0x08 returns the last value written.
- R3: The count changes only when bit 0 of the control word at 0x0C is set or when it is loaded. When enabled, it gains exactly one after every `PRESCALE` tick strobes, and never changes by more than one in a single step.
- R4: Bit 0 of the raw status at 0x14 becomes 1 one edge after the count starts equalling the match value. This includes equality reached by counting, by loading the count, or by writing the match value. The bit stays set until it is cleared, and continuing equality does not set it again after a clear.
- R5: Writing 0x1C clears each raw bit whose written bit is 1 and leaves the bits written as 0 unchanged. If a set and a clear hit the same bit on the same edge, the bit ends up set.
- R6: The mask at 0x10 (bit 0 alarm, bit 1 periodic) is readable. The masked status at 0x18 always equals raw AND mask.
- R7: `irq` is high exactly when any masked status bit is 1. It is low whenever the mask is zero.
- R8: Writing the periodic load at 0x24 sets both the reload value and the current value, which is read at 0x20. While bit 1 of 0x28 is set, each tick lowers the current value. A tick seen at value 1 sets raw bit 1 and reloads, giving one event every N ticks for a load of N. A load of 0 never raises the event, and with bit 1 of 0x28 clear the current value holds.
- R9: The match value at 0x04 and both control words read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Byte address; bits 5:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | OR of all masked status bits |

## Verification
Some properties are checked on every clock:
- The count holds while counting is disabled, and moves by at most one per edge.
- A load lands exactly at the following edge.
- The alarm bit only rises after a cycle of equality, and stays set until a clear is written.
- A periodic event rises only after a tick.
- The interrupt stays quiet under a zero mask.

The bench scenarios cover the rest:
- The exact prescaler ratio, and its phase restart on load.
- The set-beats-clear collision on one edge.
- No re-trigger on held equality.
- The periodic period and the zero-load case.
- The read-back values of every register.

// File: rtl/rtc_match_alarm.sv
module rtc_match_alarm #(
  parameter int PRESCALE = 32768,
  parameter int CW       = 32,
  parameter int PTW      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [3:0] W_CNT = 4'd0, W_MATCH = 4'd1, W_LOAD = 4'd2, W_CTRL = 4'd3,
                         W_MASK = 4'd4, W_RAW = 4'd5, W_MIS = 4'd6, W_CLR = 4'd7,
                         W_PCUR = 4'd8, W_PLOAD = 4'd9, W_PCTRL = 4'd10;

  logic [CW-1:0]  count_q, match_q, loadv_q;
  logic [PW-1:0]  pre_q;
  logic           run_q, eq_q;
  logic [1:0]     mask_q, raw_q;
  logic [PTW-1:0] ptld_q, ptcur_q;
  logic           ptrun_q;

  wire [3:0] widx   = bus_addr[5:2];
  wire       wr     = bus_sel & bus_we;
  wire       wr_ld  = wr && widx == W_LOAD;
  wire       wr_pld = wr && widx == W_PLOAD;
  wire       eq     = count_q == match_q;
  wire       al_set = eq & ~eq_q;
  wire       pt_set = ptrun_q & tick & (ptcur_q == PTW'(1));
  wire [1:0] clr    = (wr && widx == W_CLR) ? bus_wdata[1:0] : 2'b00;

  assign irq = |(raw_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      pre_q   <= '0;
    end else if (wr_ld) begin
      count_q <= bus_wdata[CW-1:0];
      pre_q   <= '0;
    end else if (run_q && tick) begin
      if (pre_q == PW'(PRESCALE - 1)) begin
        pre_q   <= '0;
        count_q <= count_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      loadv_q <= '0;
      run_q   <= 1'b0;
      mask_q  <= 2'b00;
      ptrun_q <= 1'b0;
    end else if (wr) begin
      if (widx == W_MATCH) match_q <= bus_wdata[CW-1:0];
      if (widx == W_LOAD)  loadv_q <= bus_wdata[CW-1:0];
      if (widx == W_CTRL)  run_q   <= bus_wdata[0];
      if (widx == W_MASK)  mask_q  <= bus_wdata[1:0];
      if (widx == W_PCTRL) ptrun_q <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q  <= 1'b1;
      raw_q <= 2'b00;
    end else begin
      eq_q  <= eq;
      raw_q <= (raw_q & ~clr) | {pt_set, al_set};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptld_q  <= '0;
      ptcur_q <= '0;
    end else if (wr_pld) begin
      ptld_q  <= bus_wdata[PTW-1:0];
      ptcur_q <= bus_wdata[PTW-1:0];
    end else if (ptrun_q && tick) begin
      if (ptcur_q <= PTW'(1)) ptcur_q <= ptld_q;
      else                    ptcur_q <= ptcur_q - 1'b1;
    end
  end

  always_comb begin
    case (widx)
      W_CNT:   bus_rdata = 32'(count_q);
      W_MATCH: bus_rdata = 32'(match_q);
      W_LOAD:  bus_rdata = 32'(loadv_q);
      W_CTRL:  bus_rdata = {31'd0, run_q};
      W_MASK:  bus_rdata = {30'd0, mask_q};
      W_RAW:   bus_rdata = {30'd0, raw_q};
      W_MIS:   bus_rdata = {30'd0, raw_q & mask_q};
      W_PCUR:  bus_rdata = 32'(ptcur_q);
      W_PLOAD: bus_rdata = 32'(ptld_q);
      W_PCTRL: bus_rdata = {30'd0, ptrun_q, 1'b0};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/rtc_match_alarm_chk.sv
module rtc_match_alarm_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [5:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          irq,
  input logic [CW-1:0] count,
  input logic [CW-1:0] match,
  input logic          run,
  input logic [1:0]    raw,
  input logic [1:0]    mask
);
  wire ld_wr  = bus_sel && bus_we && bus_addr[5:2] == 4'd2;
  wire clr_al = bus_sel && bus_we && bus_addr[5:2] == 4'd7 && bus_wdata[0];

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_wr) |=> $stable(count));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_wr) |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> count == $past(bus_wdata[CW-1:0]));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[0] && !clr_al) |=> raw[0]);

  a_r4_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[0]) |-> $past(count == match));

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[1]) |-> $past(tick));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq);
endmodule

bind rtc_match_alarm rtc_match_alarm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .count(count_q),
  .match(match_q), .run(run_q), .raw(raw_q), .mask(mask_q)
);

// File: tb/rtc_match_alarm_test.sv
`timescale 1ns/1ps
module rtc_match_alarm_test;
  logic clk = 0, rst_n = 0, tick = 0, bus_sel = 0, bus_we = 0, irq;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rtc_match_alarm #(.PRESCALE(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {write, addr, data_or_expected, requirement}
  localparam int NV = 22;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 6'h00, 32'h0,  4'd1},  // R1 count zero
    {1'b0, 6'h14, 32'h0,  4'd1},  // R1 raw zero
    {1'b1, 6'h04, 32'h10, 4'd9},
    {1'b0, 6'h04, 32'h10, 4'd9},  // R9 match readback
    {1'b1, 6'h08, 32'hF,  4'd2},
    {1'b0, 6'h00, 32'hF,  4'd2},  // R2 load lands
    {1'b0, 6'h08, 32'hF,  4'd2},  // R2 load readback
    {1'b0, 6'h14, 32'h0,  4'd4},  // R4 no equality yet
    {1'b1, 6'h08, 32'h10, 4'd4},
    {1'b0, 6'h14, 32'h1,  4'd4},  // R4 load into equality
    {1'b0, 6'h18, 32'h0,  4'd6},  // R6 masked with mask 0
    {1'b1, 6'h10, 32'h3,  4'd6},
    {1'b0, 6'h18, 32'h1,  4'd6},  // R6 raw AND mask
    {1'b1, 6'h1C, 32'h2,  4'd5},
    {1'b0, 6'h14, 32'h1,  4'd5},  // R5 zero bit untouched
    {1'b1, 6'h1C, 32'h1,  4'd5},
    {1'b0, 6'h14, 32'h0,  4'd5},  // R5 cleared, no retrigger on held equality
    {1'b1, 6'h04, 32'h20, 4'd4},
    {1'b1, 6'h04, 32'h10, 4'd4},
    {1'b0, 6'h14, 32'h1,  4'd4},  // R4 match write into equality
    {1'b1, 6'h0C, 32'h1,  4'd9},
    {1'b0, 6'h0C, 32'h1,  4'd9}   // R9 control readback
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    check(bus_rdata, exp, req);
    bus_sel = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check({31'd0, irq}, 32'd0, "R1 irq");
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) wr(VEC[i][41:36], VEC[i][35:4]);
      else rd(VEC[i][41:36], VEC[i][35:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R3 prescale ratio and alarm by counting; R7 irq
    wr(6'h08, 32'h1E);
    ticks(8);  rd(6'h00, 32'h1F, "R3 one step per 8 ticks");
    ticks(7);  rd(6'h00, 32'h1F, "R3 no early step");
    ticks(1);  rd(6'h00, 32'h20, "R3 second step");
    wr(6'h04, 32'h20);
    wr(6'h1C, 32'h3);
    wr(6'h08, 32'h1F);
    ticks(8);  rd(6'h14, 32'h1, "R4 count into equality");
    check({31'd0, irq}, 32'd1, "R7 irq on masked alarm");
    wr(6'h1C, 32'h3);
    check({31'd0, irq}, 32'd0, "R7 irq drops on clear");
    wr(6'h0C, 32'h0);
    ticks(20); rd(6'h00, 32'h20, "R3 hold while disabled");

    // R2 prescaler phase restart
    wr(6'h0C, 32'h1);
    ticks(5);
    wr(6'h08, 32'h100);
    ticks(7);  rd(6'h00, 32'h100, "R2 phase restarted");
    ticks(1);  rd(6'h00, 32'h101, "R2 full period after load");

    // R5 set wins over same-edge clear
    wr(6'h04, 32'h200);
    wr(6'h08, 32'h1FF);
    ticks(7);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    bus_sel = 1; bus_we = 1; bus_addr = 6'h1C; bus_wdata = 32'h1;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    rd(6'h14, 32'h1, "R5 set wins");
    wr(6'h1C, 32'h1);
    rd(6'h14, 32'h0, "R5 plain clear");
    wr(6'h0C, 32'h0);

    // R8 periodic timer
    wr(6'h10, 32'h2);
    wr(6'h24, 32'h3);
    rd(6'h20, 32'h3, "R8 load sets current");
    rd(6'h28, 32'h0, "R9 periodic ctrl reset");
    wr(6'h28, 32'h2);
    rd(6'h28, 32'h2, "R9 periodic ctrl readback");
    ticks(2);  rd(6'h20, 32'h1, "R8 counts down");
    rd(6'h14, 32'h0, "R8 no early event");
    ticks(1);  rd(6'h14, 32'h2, "R8 event at expiry");
    rd(6'h20, 32'h3, "R8 reload");
    check({31'd0, irq}, 32'd1, "R7 irq on periodic");
    wr(6'h1C, 32'h2);
    rd(6'h18, 32'h0, "R6 masked after clear");
    ticks(3);  rd(6'h14, 32'h2, "R8 period of load");
    wr(6'h1C, 32'h2);
    wr(6'h24, 32'h0);
    ticks(5);  rd(6'h14, 32'h0, "R8 zero load silent");
    wr(6'h28, 32'h0);
    wr(6'h24, 32'h5);
    ticks(4);  rd(6'h20, 32'h5, "R8 hold while disabled");

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rd(6'h00, 32'h0, "R1 count after reset");
    rd(6'h24, 32'h0, "R1 periodic load after reset");
    rd(6'h10, 32'h0, "R1 mask after reset");
    check({31'd0, irq}, 32'd0, "R1 irq after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule